// File: doc/BRIEF.md
# Serial Delta-Sigma Converter Readout Controller

This block sits on the host side of a three-wire link to a delta-sigma converter. That converter delivers each result as a 32-bit word. The three wires are an active-low chip select, a serial clock, and a data line going into the host. A start request pulls chip select low. The controller then watches the data line, which carries the converter's live "still converting" flag. It does not start the serial clock until that flag has fallen. If the flag stays high for too long, the controller gives up, raises a timeout pulse and releases chip select.

Once the flag is low, the controller produces 32 serial clock pulses. It samples the data line on each rising edge, most significant bit first. The high and low phases of each pulse last a number of system clocks chosen at start time. After the last pulse the controller releases chip select and then splits the word into its fields. It presents the 24-bit magnitude field, the sign bit and the five sub-LSB bits. It also decodes the sign and top result bit into over-range and under-range flags, and marks the word corrupt when either status bit that must read low was high. All of these appear with a one-cycle valid strobe.

Top module: `adc_frame_reader`

## Requirements
- R1: While reset is held, and after it is released with no start, chip select is high (deasserted), the serial clock is low, and the valid and timeout strobes are low.
- R2: A start request is taken only while the controller is idle. Chip select goes low in the cycle after the start is sampled. A start seen during a read has no effect: once that read ends, chip select stays high.
- R3: No serial clock edge occurs until the data line has been sampled low with chip select low. The first rising edge comes exactly H system clocks after that low sample. With a flag delay of D high samples, chip select low precedes the first rise by D+1+H samples.
- R4: If the data line is sampled high on T consecutive polling cycles, the following all happen in the same cycle: timeout pulses for one cycle, chip select returns high, and no valid strobe follows. T is the timeout input, and a value of 0 is treated as 1. A flag that falls after T-1 high samples still leads to a normal read.
- R5: The serial clock idles low and gives exactly 32 rising edges per read. Each high phase lasts H system clocks, and each low phase between rises lasts H system clocks. H is the phase-length input captured at start, with values below 2 raised to 2. Changing the phase-length input during a read has no effect.
- R6: Bits are captured most significant first on rising edges. In the captured word (bit 31 first on the wire), result = bits 28..5, sub-LSB = bits 4..0 and sign = bit 29.
- R7: Over-range is set when bits 29 and 28 are both 1. Under-range is set when both are 0. The two flags are never set together.
- R8: The corrupt flag is set when bit 30 (the always-low dummy position) or bit 31 (the end-of-conversion position) was captured high.
- R9: Chip select rises together with the final falling clock edge, at the end of the 32nd high phase. Valid pulses for exactly one cycle, in the cycle after that. All result outputs hold their values until the next valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request one read (taken only when idle) |
| sck_half_i | input | DIV_W | System clocks per serial clock phase (minimum 2) |
| eoc_timeout_i | input | TMO_W | Polling limit in system clocks (0 acts as 1) |
| sdi_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sck_o | output | 1 | Serial clock, idles low |
| valid_o | output | 1 | One-cycle strobe: result outputs updated |
| result_o | output | 24 | Result field, word bits 28..5 |
| sub_lsb_o | output | 5 | Sub-LSB field, word bits 4..0 |
| sign_o | output | 1 | Sign bit, word bit 29 (1 = positive) |
| over_range_o | output | 1 | Input above positive full scale |
| under_range_o | output | 1 | Input below negative full scale |
| corrupt_o | output | 1 | Status bit 30 or 31 captured high |
| timeout_o | output | 1 | One-cycle strobe: conversion flag never fell |

## Verification
The hardest case to reach is a status bit 31 that reads high at the first rising edge. The controller only starts clocking after it has seen that line low. The bench's converter model therefore drops the flag, waits one system clock, and then drives the word's own bit 31 before the first rise. Because every phase lasts at least two system clocks, this glitch always lands before the first sample. The timeout boundary is reached by giving the model a conversion delay of exactly T-1 and then exactly T high samples. In each read the bench measures every phase length and the offset to the first rise against the chosen delay.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    localparam int FRAME_W   = 32;
    localparam int RES_W     = 24;
    localparam int SUB_W     = 5;
    localparam int POS_EOC   = 31;
    localparam int POS_DMY   = 30;
    localparam int POS_SIGN  = 29;
    localparam int POS_TOP   = 28;
    localparam int RES_LSB   = SUB_W;
    localparam int HALF_MIN  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL,
        ST_LOW,
        ST_HIGH,
        ST_DONE
    } rd_state_e;

    typedef struct packed {
        logic [RES_W-1:0] result;
        logic [SUB_W-1:0] sub;
        logic             sign;
        logic             over;
        logic             under;
        logic             corrupt;
    } fields_t;

endpackage

// File: rtl/adc_rd_phase_timer.sv
module adc_rd_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_len,
    output logic             phase_end
);

    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        phase_end = run && (cnt_q == half_len - DIV_W'(1));
        if (!run || phase_end) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] word,
    output logic             full
);

    localparam int CNT_W = $clog2(WIDTH + 1);

    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic [CNT_W-1:0] cnt;
    } shift_t;

    shift_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clear) begin
            r_d.data = '0;
            r_d.cnt  = '0;
        end else if (shift_en && !full) begin
            r_d.data = {r_q.data[WIDTH-2:0], bit_in};
            r_d.cnt  = r_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign word = r_q.data;
    assign full = (r_q.cnt == CNT_W'(WIDTH));

endmodule

// File: rtl/adc_rd_decode.sv
module adc_rd_decode
    import adc_rd_pkg::*;
(
    input  logic [FRAME_W-1:0] word,
    output fields_t            fields
);

    logic sgn, top;

    always_comb begin
        sgn            = word[POS_SIGN];
        top            = word[POS_TOP];
        fields.result  = word[RES_LSB +: RES_W];
        fields.sub     = word[SUB_W-1:0];
        fields.sign    = sgn;
        fields.over    = sgn & top;
        fields.under   = ~sgn & ~top;
        fields.corrupt = word[POS_DMY] | word[POS_EOC];
    end

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
    import adc_rd_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [DIV_W-1:0] sck_half_i,
    input  logic [TMO_W-1:0] eoc_timeout_i,
    input  logic             sdi_i,
    output logic             cs_n_o,
    output logic             sck_o,
    output logic             valid_o,
    output logic [RES_W-1:0] result_o,
    output logic [SUB_W-1:0] sub_lsb_o,
    output logic             sign_o,
    output logic             over_range_o,
    output logic             under_range_o,
    output logic             corrupt_o,
    output logic             timeout_o
);

    localparam logic [DIV_W-1:0] HALF_FLOOR = DIV_W'(HALF_MIN);
    localparam logic [TMO_W-1:0] TMO_FLOOR  = TMO_W'(1);

    typedef struct packed {
        rd_state_e        state;
        logic             cs_n;
        logic             sck;
        logic [DIV_W-1:0] half;
        logic [TMO_W-1:0] tmo;
        logic [TMO_W-1:0] wait_cnt;
        logic             valid;
        logic             timeout;
        fields_t          out;
    } ctl_t;

    ctl_t r_d, r_q;

    logic               timer_run;
    logic               phase_end;
    logic               sh_clear;
    logic               sh_en;
    logic               sh_full;
    logic [FRAME_W-1:0] sh_word;
    fields_t            dec;

    adc_rd_phase_timer #(.DIV_W(DIV_W)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (timer_run),
        .half_len  (r_q.half),
        .phase_end (phase_end)
    );

    adc_rd_shifter #(.WIDTH(FRAME_W)) shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (sh_clear),
        .shift_en (sh_en),
        .bit_in   (sdi_i),
        .word     (sh_word),
        .full     (sh_full)
    );

    adc_rd_decode decode_i (
        .word   (sh_word),
        .fields (dec)
    );

    always_comb begin
        r_d         = r_q;
        r_d.valid   = 1'b0;
        r_d.timeout = 1'b0;
        timer_run   = (r_q.state == ST_LOW) || (r_q.state == ST_HIGH);
        sh_clear    = 1'b0;
        sh_en       = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                r_d.cs_n = 1'b1;
                r_d.sck  = 1'b0;
                if (start_i) begin
                    sh_clear     = 1'b1;
                    r_d.state    = ST_POLL;
                    r_d.cs_n     = 1'b0;
                    r_d.wait_cnt = '0;
                    r_d.half     = (sck_half_i < HALF_FLOOR) ? HALF_FLOOR : sck_half_i;
                    r_d.tmo      = (eoc_timeout_i == '0) ? TMO_FLOOR : eoc_timeout_i;
                end
            end
            ST_POLL: begin
                if (!sdi_i) begin
                    r_d.state = ST_LOW;
                end else if (r_q.wait_cnt == r_q.tmo - TMO_FLOOR) begin
                    r_d.state   = ST_IDLE;
                    r_d.cs_n    = 1'b1;
                    r_d.timeout = 1'b1;
                end else begin
                    r_d.wait_cnt = r_q.wait_cnt + TMO_FLOOR;
                end
            end
            ST_LOW: begin
                if (phase_end) begin
                    sh_en     = 1'b1;
                    r_d.sck   = 1'b1;
                    r_d.state = ST_HIGH;
                end
            end
            ST_HIGH: begin
                if (phase_end) begin
                    r_d.sck = 1'b0;
                    if (sh_full) begin
                        r_d.state = ST_DONE;
                        r_d.cs_n  = 1'b1;
                    end else begin
                        r_d.state = ST_LOW;
                    end
                end
            end
            ST_DONE: begin
                r_d.valid = 1'b1;
                r_d.out   = dec;
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
                r_d.cs_n  = 1'b1;
                r_d.sck   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.cs_n  <= 1'b1;
            r_q.half  <= HALF_FLOOR;
            r_q.tmo   <= TMO_FLOOR;
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_n_o        = r_q.cs_n;
    assign sck_o         = r_q.sck;
    assign valid_o       = r_q.valid;
    assign timeout_o     = r_q.timeout;
    assign result_o      = r_q.out.result;
    assign sub_lsb_o     = r_q.out.sub;
    assign sign_o        = r_q.out.sign;
    assign over_range_o  = r_q.out.over;
    assign under_range_o = r_q.out.under;
    assign corrupt_o     = r_q.out.corrupt;

endmodule

// File: rtl/adc_rd_checker.sv
module adc_rd_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_n_o,
    input logic sck_o,
    input logic valid_o,
    input logic timeout_o,
    input logic over_range_o,
    input logic under_range_o
);

    // R5: serial clock only runs while the converter is selected
    assert_sck_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sck_o);

    // R9: valid lasts one cycle
    assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    // R9: valid follows the release of chip select by one cycle
    assert_valid_after_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (cs_n_o && $past(cs_n_o) && !$past(cs_n_o, 2)));

    // R7: the two range flags exclude each other
    assert_range_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(over_range_o && under_range_o));

    // R4: a timeout releases chip select and carries no result
    assert_timeout_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (cs_n_o && !valid_o && !$past(cs_n_o)));

    // R4: timeout lasts one cycle
    assert_timeout_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o);

endmodule

bind adc_frame_reader adc_rd_checker checker_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_n_o        (cs_n_o),
    .sck_o         (sck_o),
    .valid_o       (valid_o),
    .timeout_o     (timeout_o),
    .over_range_o  (over_range_o),
    .under_range_o (under_range_o)
);

// File: tb/adc_frame_reader_tb_top.sv
`timescale 1ns/1ps
module adc_frame_reader_tb_top;

    localparam int DIV_W = 4;
    localparam int TMO_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [DIV_W-1:0] sck_half_i = DIV_W'(2);
    logic [TMO_W-1:0] eoc_timeout_i = TMO_W'(50);
    logic             sdi_i = 1'b1;
    logic             cs_n_o, sck_o, valid_o, sign_o;
    logic             over_range_o, under_range_o, corrupt_o, timeout_o;
    logic [23:0]      result_o;
    logic [4:0]       sub_lsb_o;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    logic [31:0] model_frame = '0;
    int          model_dly = 0;
    int          conv_cnt = 0;
    int          idx = 0;
    bit          ready = 0;
    logic        prev_sck_m = 1'b0;

    always #2.5 clk = ~clk;

    adc_frame_reader #(.DIV_W(DIV_W), .TMO_W(TMO_W)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .sck_half_i    (sck_half_i),
        .eoc_timeout_i (eoc_timeout_i),
        .sdi_i         (sdi_i),
        .cs_n_o        (cs_n_o),
        .sck_o         (sck_o),
        .valid_o       (valid_o),
        .result_o      (result_o),
        .sub_lsb_o     (sub_lsb_o),
        .sign_o        (sign_o),
        .over_range_o  (over_range_o),
        .under_range_o (under_range_o),
        .corrupt_o     (corrupt_o),
        .timeout_o     (timeout_o)
    );

    // Converter model: flag high for model_dly samples, then word shifted on falling edges
    always @(negedge clk) begin
        if (cs_n_o !== 1'b0) begin
            sdi_i    = 1'b1;
            conv_cnt = 0;
            ready    = 0;
            idx      = 0;
        end else if (!ready) begin
            if (conv_cnt >= model_dly) begin
                ready = 1;
                sdi_i = 1'b0;
            end else begin
                conv_cnt++;
                sdi_i = 1'b1;
            end
        end else if (prev_sck_m && !sck_o) begin
            idx++;
            sdi_i = (idx < 32) ? model_frame[31-idx] : 1'b1;
        end else if (idx == 0) begin
            sdi_i = model_frame[31];
        end
        prev_sck_m = sck_o;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_read(input logic [31:0] frm, input int h_in, input int dly,
                            input int tmo, input bit poke);
        int h_exp, t_exp, run, rises, bad, first_low, cs_low, cs_rise, v_at, poke_st;
        bit got_v, got_t, t_cs, exp_to, hold_ok;
        logic prv_sck, prv_cs;
        logic [23:0] cap_res;
        logic [4:0] cap_sub;
        logic cap_sign, cap_over, cap_under, cap_bad;
        h_exp = (h_in < 2) ? 2 : h_in;
        t_exp = (tmo == 0) ? 1 : tmo;
        exp_to = (dly >= t_exp);
        run = 0; rises = 0; bad = 0; first_low = -1; cs_low = 0; cs_rise = -1; v_at = -1;
        poke_st = 0; got_v = 0; got_t = 0; t_cs = 0;
        prv_sck = 1'b0; prv_cs = 1'b0;
        cap_res = '0; cap_sub = '0; cap_sign = 0; cap_over = 0; cap_under = 0; cap_bad = 0;
        model_frame = frm;
        model_dly = dly;
        sck_half_i = DIV_W'(h_in);
        eoc_timeout_i = TMO_W'(tmo);
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        for (int c = 0; c < 20000; c++) begin
            if (c > 0) @(negedge clk);
            if (poke) begin
                if (poke_st == 1) begin
                    start_i = 1'b0;
                    poke_st = 2;
                end else if (poke_st == 0 && rises == 10) begin
                    start_i = 1'b1;
                    sck_half_i = DIV_W'(h_in + 3);
                    poke_st = 1;
                end
            end
            if (!cs_n_o) cs_low++;
            if (cs_n_o && !prv_cs) cs_rise = c;
            if (sck_o !== prv_sck) begin
                if (sck_o) begin
                    rises++;
                    if (rises == 1) first_low = run;
                    else if (run != h_exp) bad++;
                end else if (run != h_exp) begin
                    bad++;
                end
                run = 1;
            end else begin
                run++;
            end
            prv_sck = sck_o;
            prv_cs = cs_n_o;
            if (timeout_o) begin
                got_t = 1;
                t_cs = cs_n_o;
                break;
            end
            if (valid_o) begin
                got_v = 1;
                v_at = c;
                cap_res = result_o; cap_sub = sub_lsb_o; cap_sign = sign_o;
                cap_over = over_range_o; cap_under = under_range_o; cap_bad = corrupt_o;
                break;
            end
        end
        start_i = 1'b0;
        chk(got_t == exp_to, "R4", "timeout raised", got_t, exp_to);
        chk(got_v == !exp_to, "R4", "valid raised", got_v, !exp_to);
        if (exp_to) begin
            chk(cs_low == t_exp, "R4", "polling cycles before timeout", cs_low, t_exp);
            chk(t_cs == 1'b1, "R4", "chip select high with timeout", t_cs, 1);
            chk(rises == 0, "R3", "clock edges during failed poll", rises, 0);
        end else if (got_v) begin
            chk(first_low == dly + 1 + h_exp, "R3", "samples before first rise",
                first_low, dly + 1 + h_exp);
            chk(rises == 32, "R5", "rising edges", rises, 32);
            chk(bad == 0, "R5", "phase length mismatches", bad, 0);
            chk(v_at - cs_rise == 1, "R9", "valid after release", v_at - cs_rise, 1);
            chk(cap_res == frm[28:5], "R6", "result field", cap_res, frm[28:5]);
            chk(cap_sub == frm[4:0], "R6", "sub-LSB field", cap_sub, frm[4:0]);
            chk(cap_sign == frm[29], "R6", "sign", cap_sign, frm[29]);
            chk(cap_over == (frm[29] & frm[28]), "R7", "over-range", cap_over, frm[29] & frm[28]);
            chk(cap_under == (!frm[29] & !frm[28]), "R7", "under-range", cap_under,
                !frm[29] & !frm[28]);
            chk(cap_bad == (frm[30] | frm[31]), "R8", "corrupt", cap_bad, frm[30] | frm[31]);
        end
        @(negedge clk);
        chk(valid_o == 1'b0 && timeout_o == 1'b0, "R9", "strobe width", valid_o | timeout_o, 0);
        hold_ok = 1;
        for (int k = 0; k < 8; k++) begin
            if (k > 0) @(negedge clk);
            if (cs_n_o !== 1'b1 || valid_o !== 1'b0) hold_ok = 0;
            if (got_v && result_o !== cap_res) hold_ok = 0;
        end
        if (poke)
            chk(hold_ok, "R2", "start during read ignored", hold_ok, 1);
        else
            chk(hold_ok, "R9", "outputs hold while idle", hold_ok, 1);
    endtask

    initial begin
        #(5ns * 150000);
        if (!finished) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int n;
        logic [31:0] frm;
        logic [22:0] body;
        repeat (3) @(negedge clk);
        chk(cs_n_o === 1'b1 && sck_o === 1'b0 && valid_o === 1'b0 && timeout_o === 1'b0,
            "R1", "outputs in reset", {cs_n_o, sck_o, valid_o, timeout_o}, 4'b1000);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(cs_n_o === 1'b1 && sck_o === 1'b0 && valid_o === 1'b0 && timeout_o === 1'b0,
            "R1", "outputs after reset", {cs_n_o, sck_o, valid_o, timeout_o}, 4'b1000);

        // Sweep: phase length x status pair x both corrupt positions
        n = 0;
        for (int h = 2; h <= 4; h++) begin
            for (int st = 0; st < 16; st++) begin
                body = 23'((n * 32'h2F5A3 + 7) & 32'h7FFFFF);
                frm = {st[3], st[2], st[1], st[0], body, 5'((n * 7) % 32)};
                run_read(frm, h, n % 4, 50, 1'b0);
                n++;
            end
        end

        // R5: phase lengths below the floor are raised to 2
        run_read(32'h2ABC_DEF1, 0, 1, 50, 1'b0);
        run_read(32'h1234_5678, 1, 2, 50, 1'b0);

        // R4: timeout boundary, flag falls after T-1 samples vs stays for T
        run_read(32'h2000_0000, 3, 4, 5, 1'b0);
        run_read(32'h2000_0000, 3, 5, 5, 1'b0);
        run_read(32'h3FFF_FFFF, 2, 0, 0, 1'b0);
        run_read(32'h3FFF_FFFF, 2, 1, 0, 1'b0);

        // R2 and R5: start and phase-length change during a read are ignored
        run_read(32'h1F0F_0F0F, 3, 2, 50, 1'b1);
        run_read(32'h0000_0000, 2, 0, 50, 1'b1);

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule